// File: doc/BRIEF.md
# Quad-I/O Fast-Read Flash Responder

This block plays the device side of a serial flash that answers only the quad-I/O fast-read command. It serves the reads from a small internal byte array. A host controller drives the serial clock, the active-low select and four data lines. The block decodes the command, the 24-bit address and the 8-bit mode field, lets four dummy clocks pass, and then streams bytes back four bits per clock. The read address steps up after each byte and wraps at the end of the array. The stream runs until select is released. Before any host traffic, the array is filled through a synchronous write port on the system clock.

The mode field can arm a continuous-read state. While this state is armed, the next select-low period skips the opcode and starts straight in the address phase. Each transaction re-evaluates the state from its own mode bits. The serial interface is oversampled: select, serial clock and the four data inputs pass through a two-flop synchronizer on the system clock. Edges are then detected on the synchronized serial clock. Inputs are taken on rising serial-clock edges, and outputs change on falling ones. The data lines appear as a separate input bus, output bus and shared output enable, so a pad ring can form the bidirectional pins. The system clock must run at least six times faster than the serial clock, and select must fall at least three system clocks before the first rising serial-clock edge.

Top module: `qspi_flash_resp`

## Requirements
- R1: A transaction whose first eight rising serial-clock edges carry 8'hEB on io_in[0], most significant bit first, is accepted as a quad read, provided quad_en is 1. The block then returns array data.
- R2: While quad_en is 0, the 8'hEB opcode is ignored. io_oe stays 0 for the whole select-low period, and no continuous-read state is armed.
- R3: After the opcode come six address nibbles on io_in[3:0], most significant nibble first, with io_in[3] as the most significant bit. Only the low ADDR_W address bits select the array byte.
- R4: io_oe is 0 after reset and stays 0 through the opcode, address, mode and dummy clocks. The first drive happens on the falling serial-clock edge that follows the fourth dummy rising edge.
- R5: Each byte goes out as two nibbles, the high nibble first, with io_out[3] carrying the most significant bit of each nibble.
- R6: Two mode nibbles follow the address. If bits [1:0] of the first mode nibble (M5:M4) are 2'b10, the next select-low period begins directly with the address nibbles, with no opcode.
- R7: Any other M5:M4 value returns the block to expecting an opcode. In particular, eight clocks with io_in[0] held at 1 during the continuous state clear that state.
- R8: After every byte the read address increments by one, wrapping from 2**ADDR_W-1 to 0. Streaming continues until select rises.
- R9: Select rising at any point ends the transaction and drops io_oe within three system clocks. It leaves the continuous-read state unchanged.
- R10: An opcode other than 8'hEB causes no output for the rest of that select-low period. It also leaves the continuous-read state unchanged.
- R11: When wr_en is 1 on a system-clock edge, wr_data is written to array entry wr_addr. Later reads return that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for the write port, synchronizers and control |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Array write strobe |
| wr_addr | input | ADDR_W | Array write index |
| wr_data | input | 8 | Array write byte |
| quad_en | input | 1 | Enables acceptance of the quad read command |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select from the host |
| io_in | input | 4 | Data lines as seen at the pads |
| io_out | output | 4 | Data nibble driven toward the host |
| io_oe | output | 1 | Output enable for all four data lines |

## Verification
A serial-clock edge takes effect three system-clock edges after it is driven: two synchronizer stages, then one register stage. An output nibble therefore settles three system clocks after the falling serial edge that launches it. The bench holds each serial-clock level for six system clocks and samples io_out and io_oe on the fifth clock after each falling edge, well clear of the next rising edge. When select rises, the bench waits four system clocks before it checks that io_oe is low. Quiet phases are checked with a monitor that counts every system clock on which io_oe is high between select falling and the end of the dummy clocks.

// File: rtl/qspi_resp_pkg.sv
package qspi_resp_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_OPC   = 3'd1,
    PH_ADDR  = 3'd2,
    PH_MODE  = 3'd3,
    PH_DUMMY = 3'd4,
    PH_DATA  = 3'd5,
    PH_SKIP  = 3'd6
  } phase_t;

  localparam logic [7:0] QREAD_OPC = 8'hEB;
  localparam int unsigned OPC_BITS  = 8;
  localparam int unsigned ADDR_NIBS = 6;
  localparam int unsigned DUMMY_CLKS = 4;
endpackage

// File: rtl/qspi_resp_sync.sv
module qspi_resp_sync #(
  parameter int unsigned W = 6,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[g];
        s2 <= RST_VAL[g];
      end else begin
        s1 <= d[g];
        s2 <= s1;
      end
    end
    assign q[g] = s2;
  end
endmodule

// File: rtl/qspi_resp_mem.sv
module qspi_resp_mem #(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  assign rd_data = store[rd_addr];
endmodule

// File: rtl/qspi_resp_fsm.sv
module qspi_resp_fsm
  import qspi_resp_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              cs_s,
  input  logic [3:0]        io_s,
  input  logic              quad_en,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [3:0]        io_out,
  output logic              io_oe,
  output phase_t            phase_q,
  output logic              cont_q,
  output logic              nib_lo_q,
  output logic              sclk_rise
);
  localparam int unsigned CNT_W = $clog2(OPC_BITS);
  localparam logic [CNT_W-1:0] OPC_LAST   = CNT_W'(OPC_BITS - 1);
  localparam logic [CNT_W-1:0] ADDR_LAST  = CNT_W'(ADDR_NIBS - 1);
  localparam logic [CNT_W-1:0] DUMMY_LAST = CNT_W'(DUMMY_CLKS - 1);

  phase_t            phase_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [6:0]        opc_q, opc_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [1:0]        mhi_q, mhi_n;
  logic              cont_n, nib_lo_n, oe_n, sclk_q;
  logic [3:0]        dout_q, dout_n;
  logic              sclk_fall;

  assign sclk_rise = sclk_s & ~sclk_q;
  assign sclk_fall = ~sclk_s & sclk_q;

  always_comb begin
    phase_n  = phase_q;
    cnt_n    = cnt_q;
    opc_n    = opc_q;
    addr_n   = addr_q;
    mhi_n    = mhi_q;
    cont_n   = cont_q;
    nib_lo_n = nib_lo_q;
    oe_n     = io_oe;
    dout_n   = dout_q;
    if (cs_s) begin
      phase_n  = PH_IDLE;
      oe_n     = 1'b0;
      cnt_n    = '0;
      nib_lo_n = 1'b0;
    end else if (phase_q == PH_IDLE) begin
      phase_n = cont_q ? PH_ADDR : PH_OPC;
      cnt_n   = '0;
    end else if (sclk_rise) begin
      unique case (phase_q)
        PH_OPC: begin
          opc_n = {opc_q[5:0], io_s[0]};
          if (cnt_q == OPC_LAST) begin
            phase_n = ({opc_q, io_s[0]} == QREAD_OPC && quad_en) ? PH_ADDR : PH_SKIP;
            cnt_n   = '0;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        PH_ADDR: begin
          addr_n = ADDR_W'({addr_q, io_s});
          if (cnt_q == ADDR_LAST) begin
            phase_n = PH_MODE;
            cnt_n   = '0;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        PH_MODE: begin
          if (cnt_q == '0) begin
            mhi_n = io_s[1:0];
            cnt_n = CNT_W'(1);
          end else begin
            cont_n  = (mhi_q == 2'b10);
            phase_n = PH_DUMMY;
            cnt_n   = '0;
          end
        end
        PH_DUMMY: begin
          if (cnt_q == DUMMY_LAST) begin
            phase_n  = PH_DATA;
            cnt_n    = '0;
            nib_lo_n = 1'b0;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        PH_DATA: begin
          nib_lo_n = ~nib_lo_q;
          if (nib_lo_q) addr_n = addr_q + 1'b1;
        end
        default: ;
      endcase
    end else if (sclk_fall && phase_q == PH_DATA) begin
      oe_n   = 1'b1;
      dout_n = nib_lo_q ? rd_data[3:0] : rd_data[7:4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      opc_q    <= '0;
      addr_q   <= '0;
      mhi_q    <= '0;
      cont_q   <= 1'b0;
      nib_lo_q <= 1'b0;
      io_oe    <= 1'b0;
      dout_q   <= '0;
      sclk_q   <= 1'b0;
    end else begin
      phase_q  <= phase_n;
      cnt_q    <= cnt_n;
      opc_q    <= opc_n;
      addr_q   <= addr_n;
      mhi_q    <= mhi_n;
      cont_q   <= cont_n;
      nib_lo_q <= nib_lo_n;
      io_oe    <= oe_n;
      dout_q   <= dout_n;
      sclk_q   <= sclk_s;
    end
  end

  assign rd_addr = addr_q;
  assign io_out  = dout_q;
endmodule

// File: rtl/qspi_flash_resp.sv
module qspi_flash_resp
  import qspi_resp_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              quad_en,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic [3:0]        io_in,
  output logic [3:0]        io_out,
  output logic              io_oe
);
  localparam int unsigned PIN_W = 6;

  logic [PIN_W-1:0]  pins_s;
  logic              cs_s, sclk_s, cont_q, nib_lo_q, sclk_rise;
  logic [3:0]        io_s;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_data;
  phase_t            phase_q;

  qspi_resp_sync #(.W(PIN_W), .RST_VAL(6'b100000)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, io_in}), .q(pins_s)
  );

  assign cs_s   = pins_s[5];
  assign sclk_s = pins_s[4];
  assign io_s   = pins_s[3:0];

  qspi_resp_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  qspi_resp_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .cs_s(cs_s), .io_s(io_s),
    .quad_en(quad_en), .rd_data(rd_data), .rd_addr(rd_addr),
    .io_out(io_out), .io_oe(io_oe), .phase_q(phase_q), .cont_q(cont_q),
    .nib_lo_q(nib_lo_q), .sclk_rise(sclk_rise)
  );
endmodule

// File: rtl/qspi_flash_resp_chk.sv
module qspi_flash_resp_chk
  import qspi_resp_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_s,
  input logic              io_oe,
  input phase_t            phase_q,
  input logic              cont_q,
  input logic              nib_lo_q,
  input logic              sclk_rise,
  input logic [ADDR_W-1:0] rd_addr
);
  p_quiet_deselect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !io_oe);

  p_drive_only_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe |-> phase_q == PH_DATA);

  p_skip_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_SKIP |-> !io_oe);

  p_cont_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q != PH_MODE |=> $stable(cont_q));

  p_resume_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && !cs_s && cont_q) |=> phase_q == PH_ADDR);

  p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DATA && sclk_rise && nib_lo_q && !cs_s)
      |=> rd_addr == $past(rd_addr) + 1'b1);
endmodule

bind qspi_flash_resp qspi_flash_resp_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .io_oe(io_oe), .phase_q(phase_q),
  .cont_q(cont_q), .nib_lo_q(nib_lo_q), .sclk_rise(sclk_rise), .rd_addr(rd_addr)
);

// File: tb/qspi_flash_resp_bench.sv
module qspi_flash_resp_bench;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, wr_en, quad_en, sclk, cs_n;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic [3:0]    io_in;
  wire  [3:0]    io_out;
  wire           io_oe;

  int tests = 0, fails = 0, oe_hits = 0;
  bit done = 1'b0;
  logic [7:0] model [DEPTH];

  qspi_flash_resp #(.ADDR_W(AW)) u_qspi_flash_resp (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .quad_en(quad_en), .sclk(sclk), .cs_n(cs_n), .io_in(io_in),
    .io_out(io_out), .io_oe(io_oe)
  );

  always @(negedge clk) if (io_oe === 1'b1) oe_hits++;

  function automatic logic [7:0] pat(int i);
    return 8'((i * 29 + 7) ^ (i >> 2));
  endfunction

  task automatic check(bit ok, string req, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick(input logic [3:0] d);
    io_in = d;
    repeat (6) @(negedge clk);
    sclk = 1'b1;
    repeat (6) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic sel();
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic desel();
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic header(bit with_op, logic [7:0] op, logic [23:0] a, logic [7:0] m);
    if (with_op) for (int i = 7; i >= 0; i--) tick({3'b000, op[i]});
    for (int i = 5; i >= 0; i--) tick(a[i*4 +: 4]);
    tick(m[7:4]);
    tick(m[3:0]);
    for (int i = 0; i < 4; i++) tick(4'h0);
  endtask

  task automatic nib(output logic [3:0] v, output logic oe);
    repeat (5) @(negedge clk);
    v  = io_out;
    oe = io_oe;
    @(negedge clk);
    sclk = 1'b1;
    repeat (6) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic get_byte(int a, string req);
    logic [3:0] h, l;
    logic oh, ol;
    logic [7:0] e;
    e = model[a % DEPTH];
    nib(h, oh);
    nib(l, ol);
    check(oh && ol && {h, l} == e, req, {22'd0, oh, ol, h, l}, {22'd0, 2'b11, e});
  endtask

  task automatic read_txn(bit with_op, logic [23:0] a, logic [7:0] m, int n, string req);
    int base;
    sel();
    base = oe_hits;
    header(with_op, 8'hEB, a, m);
    check(oe_hits == base, "R4", oe_hits - base, 0);
    for (int k = 0; k < n; k++) get_byte(int'(a[AW-1:0]) + k, req);
    desel();
  endtask

  task automatic quiet_txn(logic [7:0] op, logic [23:0] a, logic [7:0] m, int nclk, string req);
    int base;
    sel();
    base = oe_hits;
    header(1'b1, op, a, m);
    for (int k = 0; k < nclk; k++) tick(4'h0);
    check(oe_hits == base, req, oe_hits - base, 0);
    desel();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] hv;
    logic ho;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    quad_en = 1'b1; sclk = 1'b0; cs_n = 1'b1; io_in = 4'h0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(io_oe == 1'b0, "R4", {31'd0, io_oe}, 0);

    // R11: preload the whole array through the write port
    for (int i = 0; i < DEPTH; i++) begin
      model[i] = pat(i);
      wr_en = 1'b1; wr_addr = AW'(i); wr_data = pat(i);
      @(negedge clk);
    end
    wr_en = 1'b0;

    read_txn(1'b1, 24'h00000A, 8'h00, 4, "R1");
    read_txn(1'b1, 24'h000021, 8'hF0, 2, "R5");

    // R3: every start address, upper address bits set to non-zero junk
    for (int s = 0; s < DEPTH; s++)
      read_txn(1'b1, 24'hB5A5C0 | 24'(s), 8'h00, 2, "R3");

    read_txn(1'b1, 24'h00003E, 8'h00, 5, "R8");

    model[7] = 8'h5A;
    wr_en = 1'b1; wr_addr = AW'(7); wr_data = 8'h5A;
    @(negedge clk);
    wr_en = 1'b0;
    read_txn(1'b1, 24'h000007, 8'h00, 1, "R11");

    quad_en = 1'b0;
    quiet_txn(8'hEB, 24'h000010, 8'h20, 4, "R2");
    quad_en = 1'b1;
    read_txn(1'b1, 24'h000010, 8'h00, 1, "R2");

    quiet_txn(8'h0B, 24'h000012, 8'h00, 4, "R10");
    read_txn(1'b1, 24'h000012, 8'h00, 1, "R10");

    read_txn(1'b1, 24'h000020, 8'h20, 1, "R6");
    read_txn(1'b0, 24'h000030, 8'h20, 2, "R6");
    read_txn(1'b0, 24'h000005, 8'hA5, 1, "R6");

    // R9: abort during the address, state is kept
    sel();
    for (int i = 0; i < 3; i++) tick(4'h3);
    desel();
    check(io_oe == 1'b0, "R9", {31'd0, io_oe}, 0);
    read_txn(1'b0, 24'h000015, 8'h20, 1, "R9");

    // R9: abort during data
    sel();
    header(1'b0, 8'hEB, 24'h000016, 8'h20);
    get_byte(16'h16, "R9");
    nib(hv, ho);
    check(ho == 1'b1, "R9", {31'd0, ho}, 1);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    check(io_oe == 1'b0, "R9", {31'd0, io_oe}, 0);
    repeat (4) @(negedge clk);

    read_txn(1'b0, 24'h000018, 8'h00, 1, "R7");
    read_txn(1'b1, 24'h000019, 8'h00, 1, "R7");

    // R7: eight clocks with IO0 high clear the continuous state
    read_txn(1'b1, 24'h000022, 8'h20, 1, "R6");
    sel();
    for (int i = 0; i < 8; i++) tick(4'h1);
    desel();
    read_txn(1'b1, 24'h000023, 8'h00, 1, "R7");

    read_txn(1'b1, 24'h000024, 8'h30, 1, "R7");
    read_txn(1'b1, 24'h000025, 8'h00, 1, "R7");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule